// File: doc/BRIEF.md
# Serial Register Access Controller

This block is the slave side of the serial port of a converter's digital core. An external host supplies a serial clock. On each transfer the host first shifts in an 8-bit instruction. The instruction gives the direction, a byte count of one to four, and a starting byte address. One to four data bytes then move between the host and a small register file. The file holds a 32-bit configuration word, two 24-bit calibration words (offset and full-scale), and a read-only 24-bit conversion result that enters the block on a port.

The serial clock and the input data pass through a synchroniser into the system clock domain, and both clock edges are detected there. Read data changes after a detected rising edge. Input data is taken at a detected falling edge. Three bits of the configuration word affect reads only: the byte direction, the bit direction, and which output pin carries the data. If a transfer stops part way for too long, the block drops it and waits for a new instruction. No register is changed when this happens.

Top module: `ser_reg_access`

## Requirements
- R1: After a synchronous reset, cfg_o is 0x00010017, ofs_o and fsc_o are 0, and sdio_oe and sdout_oe are low.
- R2: The instruction is taken MSB first. Bit 7 selects read (1) or write (0). Bits 6:5 hold the byte count minus one. Bit 4 is unused. Bits 3:0 hold the start byte address. The transfer ends after exactly that many data bytes.
- R3: Byte addresses 0-2 read the low, middle and high bytes of dor_i. Addresses 4-7 hold configuration bytes 0-3. Addresses 8-A hold offset bytes 0-2, and C-E hold full-scale bytes 0-2. Reads of addresses 3, B and F return 0x00. Writes to 0-3, B and F change nothing.
- R4: Write data is taken MSB first. The first byte goes to the addressed byte, and each later byte goes to the next lower address.
- R5: For reads, configuration bit 26 sets the address direction. With 0, the address steps down after each byte. With 1, it steps up.
- R6: For reads, configuration bit 25 sets the bit direction. With 0 the bits go out MSB first, and with 1 they go out LSB first. Writes are always taken MSB first.
- R7: The output bit changes only after a detected rising serial clock edge. It holds its value past the following falling edge.
- R8: Suppose a transfer is in progress (mid-instruction or in the data phase) and sees no serial clock edge for 8×BIT_CLKS system clocks. The block then returns to waiting for an instruction, and the partial byte is discarded. Shorter stalls have no effect.
- R9: Configuration bit 24 selects the read output pin. With 0, sdio_oe is driven. With 1, sdout_oe is driven and sdio_oe stays low.
- R10: The output enables are low while the instruction is shifted in and throughout every write.
- R11: The registers change only on the falling edge that completes a write byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Serial data in, from the shared data pin |
| dor_i | input | 24 | Current conversion result |
| sdio_o | output | 1 | Read data toward the shared data pin |
| sdio_oe | output | 1 | Output enable of the shared data pin |
| sdout_o | output | 1 | Read data toward the dedicated output pin |
| sdout_oe | output | 1 | Output enable of the dedicated output pin |
| cfg_o | output | 32 | Configuration word |
| ofs_o | output | 24 | Offset calibration word |
| fsc_o | output | 24 | Full-scale calibration word |

## Verification
The assertions check four rules on every cycle. The output bit never moves without a detected rising edge. The registers stay still except after a falling edge, and stay still while read data is being driven. The active output enable always matches the pin-select bit. No transfer stays busy beyond the stall limit. The bench scenarios show the rest: the address map and byte stepping, the reversed bit and byte orders on reads, the exact byte count, the reset value, and the recovery after a stall. These are byte values and sequences that only a complete transfer can show.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int WORD_W = 32;

  // Configuration bits that steer the read path.
  localparam int CFG_PIN_SEL_BIT = 24;
  localparam int CFG_LSB_FIRST_BIT = 25;
  localparam int CFG_ASCEND_BIT = 26;

  typedef enum logic [1:0] {
    RG_DOR = 2'd0,
    RG_CFG = 2'd1,
    RG_OFS = 2'd2,
    RG_FSC = 2'd3
  } region_e;

  typedef enum logic {
    XS_INSN = 1'b0,
    XS_DATA = 1'b1
  } xstate_e;
endpackage

// File: rtl/sra_front.sv
module sra_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic dat_i,
  output logic rise_o,
  output logic fall_o,
  output logic dat_o
);
  logic [1:0] pipe_q [STAGES];
  logic       sclk_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= 2'b00;
      sclk_prev_q <= 1'b0;
    end else begin
      pipe_q[0] <= {sclk_i, dat_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      sclk_prev_q <= pipe_q[STAGES-1][1];
    end
  end

  assign rise_o = pipe_q[STAGES-1][1] & ~sclk_prev_q;
  assign fall_o = ~pipe_q[STAGES-1][1] & sclk_prev_q;
  assign dat_o  = pipe_q[STAGES-1][0];
endmodule

// File: rtl/sra_regfile.sv
module sra_regfile
  import sra_pkg::*;
#(
  parameter logic [WORD_W-1:0] CMD_RESET = 32'h0001_0017,
  parameter int CAL_BYTES = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [BYTE_W-1:0]        wdata_i,
  input  logic [CAL_BYTES*8-1:0]   dor_i,
  output logic [BYTE_W-1:0]        rdata_o,
  output logic [WORD_W-1:0]        cfg_o,
  output logic [CAL_BYTES*8-1:0]   ofs_o,
  output logic [CAL_BYTES*8-1:0]   fsc_o
);
  localparam int CFG_BYTES = WORD_W / BYTE_W;
  localparam int PAD_W = WORD_W - CAL_BYTES * 8;

  region_e    reg_sel;
  logic [1:0] byte_sel;
  logic [WORD_W-1:0] word;

  assign reg_sel  = region_e'(addr_i[3:2]);
  assign byte_sel = addr_i[1:0];

  for (genvar b = 0; b < CFG_BYTES; b++) begin : g_cfg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= CMD_RESET[8*b +: 8];
      else if (we_i && reg_sel == RG_CFG && byte_sel == 2'(b)) q <= wdata_i;
    end
    assign cfg_o[8*b +: 8] = q;
  end

  for (genvar b = 0; b < CAL_BYTES; b++) begin : g_cal
    logic [BYTE_W-1:0] ofs_q;
    logic [BYTE_W-1:0] fsc_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        ofs_q <= '0;
        fsc_q <= '0;
      end else if (we_i && byte_sel == 2'(b)) begin
        if (reg_sel == RG_OFS) ofs_q <= wdata_i;
        if (reg_sel == RG_FSC) fsc_q <= wdata_i;
      end
    end
    assign ofs_o[8*b +: 8] = ofs_q;
    assign fsc_o[8*b +: 8] = fsc_q;
  end

  always_comb begin
    case (reg_sel)
      RG_DOR:  word = {{PAD_W{1'b0}}, dor_i};
      RG_CFG:  word = cfg_o;
      RG_OFS:  word = {{PAD_W{1'b0}}, ofs_o};
      default: word = {{PAD_W{1'b0}}, fsc_o};
    endcase
    rdata_o = word[{byte_sel, 3'b000} +: 8];
  end
endmodule

// File: rtl/sra_xfer.sv
module sra_xfer
  import sra_pkg::*;
#(
  parameter int TMO_CYCLES = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  input  logic [BYTE_W-1:0] rdata_i,
  input  logic              lsb_first_i,
  input  logic              ascend_i,
  input  logic              pin_sel_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              sdo_o,
  output logic              sdio_oe_o,
  output logic              sdout_oe_o,
  output logic              busy_o
);
  localparam int TW = $clog2(TMO_CYCLES) + 1;

  xstate_e           st_q;
  logic [2:0]        bit_q;
  logic [6:0]        sh_q;
  logic              rd_q;
  logic [1:0]        left_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] rbyte_q;
  logic              sdo_q;
  logic              sdio_oe_q;
  logic              sdout_oe_q;
  logic [TW-1:0]     idle_q;

  logic              quiet;
  logic              tmo_hit;
  logic              last_bit;
  logic              rd_phase;
  logic [BYTE_W-1:0] src;
  logic [2:0]        sel;

  assign quiet    = ~rise_i & ~fall_i;
  assign busy_o   = (st_q == XS_DATA) || (bit_q != 3'd0);
  assign tmo_hit  = busy_o && quiet && (idle_q == TW'(TMO_CYCLES - 1));
  assign last_bit = (bit_q == 3'd7);
  assign rd_phase = (st_q == XS_DATA) && rd_q;
  assign we_o     = fall_i && (st_q == XS_DATA) && !rd_q && last_bit;
  assign wdata_o  = {sh_q, din_i};
  assign addr_o   = addr_q;
  assign src      = (bit_q == 3'd0) ? rdata_i : rbyte_q;
  assign sel      = lsb_first_i ? bit_q : 3'd7 - bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= XS_INSN;
      bit_q      <= '0;
      sh_q       <= '0;
      rd_q       <= 1'b0;
      left_q     <= '0;
      addr_q     <= '0;
      rbyte_q    <= '0;
      sdo_q      <= 1'b0;
      sdio_oe_q  <= 1'b0;
      sdout_oe_q <= 1'b0;
      idle_q     <= '0;
    end else begin
      sdio_oe_q  <= rd_phase && !pin_sel_i;
      sdout_oe_q <= rd_phase && pin_sel_i;
      if (tmo_hit) begin
        st_q   <= XS_INSN;
        bit_q  <= '0;
        idle_q <= '0;
      end else begin
        idle_q <= (busy_o && quiet) ? idle_q + 1'b1 : '0;
        if (fall_i) begin
          bit_q <= bit_q + 3'd1;
          sh_q  <= {sh_q[5:0], din_i};
          if (last_bit) begin
            if (st_q == XS_INSN) begin
              rd_q   <= sh_q[6];
              left_q <= sh_q[5:4];
              addr_q <= {sh_q[2:0], din_i};
              st_q   <= XS_DATA;
            end else if (left_q == 2'd0) begin
              st_q <= XS_INSN;
            end else begin
              left_q <= left_q - 1'b1;
              addr_q <= (rd_q && ascend_i) ? addr_q + 1'b1 : addr_q - 1'b1;
            end
          end
        end
        if (rise_i && rd_phase) begin
          if (bit_q == 3'd0) rbyte_q <= rdata_i;
          sdo_q <= src[sel];
        end
      end
    end
  end

  assign sdo_o      = sdo_q;
  assign sdio_oe_o  = sdio_oe_q;
  assign sdout_oe_o = sdout_oe_q;
endmodule

// File: rtl/ser_reg_access.sv
module ser_reg_access
  import sra_pkg::*;
#(
  parameter int BIT_CLKS = 16,
  parameter int TMO_BITS = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [31:0] CMD_RESET = 32'h0001_0017
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclk_i,
  input  logic        sdio_i,
  input  logic [23:0] dor_i,
  output logic        sdio_o,
  output logic        sdio_oe,
  output logic        sdout_o,
  output logic        sdout_oe,
  output logic [31:0] cfg_o,
  output logic [23:0] ofs_o,
  output logic [23:0] fsc_o
);
  localparam int TMO_CYCLES = BIT_CLKS * TMO_BITS;

  logic              sclk_rise;
  logic              sclk_fall;
  logic              din_s;
  logic [ADDR_W-1:0] addr;
  logic              we;
  logic [BYTE_W-1:0] wdata;
  logic [BYTE_W-1:0] rdata;
  logic              sdo;
  logic              busy;

  sra_front #(.STAGES(SYNC_STAGES)) front_i (
    .clk    (clk),
    .rst    (rst),
    .sclk_i (sclk_i),
    .dat_i  (sdio_i),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall),
    .dat_o  (din_s)
  );

  sra_regfile #(.CMD_RESET(CMD_RESET), .CAL_BYTES(3)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .dor_i   (dor_i),
    .rdata_o (rdata),
    .cfg_o   (cfg_o),
    .ofs_o   (ofs_o),
    .fsc_o   (fsc_o)
  );

  sra_xfer #(.TMO_CYCLES(TMO_CYCLES)) xfer_i (
    .clk         (clk),
    .rst         (rst),
    .rise_i      (sclk_rise),
    .fall_i      (sclk_fall),
    .din_i       (din_s),
    .rdata_i     (rdata),
    .lsb_first_i (cfg_o[CFG_LSB_FIRST_BIT]),
    .ascend_i    (cfg_o[CFG_ASCEND_BIT]),
    .pin_sel_i   (cfg_o[CFG_PIN_SEL_BIT]),
    .addr_o      (addr),
    .we_o        (we),
    .wdata_o     (wdata),
    .sdo_o       (sdo),
    .sdio_oe_o   (sdio_oe),
    .sdout_oe_o  (sdout_oe),
    .busy_o      (busy)
  );

  assign sdio_o  = sdo;
  assign sdout_o = sdo;
endmodule

// File: rtl/sra_chk.sv
module sra_chk #(
  parameter int TMO_CYCLES = 128,
  parameter logic [31:0] CMD_RESET = 32'h0001_0017
) (
  input logic        clk,
  input logic        rst,
  input logic        rise,
  input logic        fall,
  input logic        busy,
  input logic        sdo,
  input logic        sdio_oe,
  input logic        sdout_oe,
  input logic [31:0] cfg_o,
  input logic [23:0] ofs_o,
  input logic [23:0] fsc_o
);
  localparam int CW = $clog2(TMO_CYCLES) + 2;
  logic [CW-1:0] stall_cnt;

  always_ff @(posedge clk) begin
    if (rst) stall_cnt <= '0;
    else if (busy && !rise && !fall) begin
      if (stall_cnt != {CW{1'b1}}) stall_cnt <= stall_cnt + 1'b1;
    end else stall_cnt <= '0;
  end

  p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfg_o == CMD_RESET && ofs_o == 24'h0 && fsc_o == 24'h0 && !sdio_oe && !sdout_oe));

  p_out_after_rise_r7: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(sdo));

  p_stall_limit_r8: assert property (@(posedge clk) disable iff (rst)
    (stall_cnt > CW'(TMO_CYCLES)) |-> !busy);

  p_dedicated_pin_r9: assert property (@(posedge clk) disable iff (rst)
    sdout_oe |-> cfg_o[24]);

  p_shared_pin_r9: assert property (@(posedge clk) disable iff (rst)
    sdio_oe |-> !cfg_o[24]);

  p_regs_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !fall |=> ($stable(cfg_o) && $stable(ofs_o) && $stable(fsc_o)));

  p_no_write_while_driving_r11: assert property (@(posedge clk) disable iff (rst)
    (sdio_oe || sdout_oe) |=> ($stable(cfg_o) && $stable(ofs_o) && $stable(fsc_o)));
endmodule

bind ser_reg_access sra_chk #(.TMO_CYCLES(TMO_CYCLES), .CMD_RESET(CMD_RESET)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .rise     (sclk_rise),
  .fall     (sclk_fall),
  .busy     (busy),
  .sdo      (sdo),
  .sdio_oe  (sdio_oe),
  .sdout_oe (sdout_oe),
  .cfg_o    (cfg_o),
  .ofs_o    (ofs_o),
  .fsc_o    (fsc_o)
);

// File: tb/ser_reg_access_tb_top.sv
`timescale 1ns/1ps
module ser_reg_access_tb_top;
  localparam int BIT_CLKS = 16;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic sdio_i = 1'b0;
  logic [23:0] dor = 24'hA5C381;
  logic sdio_o, sdio_oe, sdout_o, sdout_oe;
  logic [31:0] cfg_o;
  logic [23:0] ofs_o, fsc_o;

  int checks = 0;
  int fails = 0;
  int hold_err = 0;
  logic last_bit;
  logic saw_sdio, saw_sdout;
  logic [31:0] got;

  always #2.5 clk = ~clk;

  ser_reg_access #(.BIT_CLKS(BIT_CLKS)) dut_i (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdio_i(sdio_i), .dor_i(dor),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdout_o(sdout_o), .sdout_oe(sdout_oe),
    .cfg_o(cfg_o), .ofs_o(ofs_o), .fsc_o(fsc_o)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_io(input logic d);
    sclk = 1'b1;
    sdio_i = d;
    repeat (HALF) @(negedge clk);
    last_bit = sdio_oe ? sdio_o : sdout_o;
    if (sdio_oe) saw_sdio = 1'b1;
    if (sdout_oe) saw_sdout = 1'b1;
    sclk = 1'b0;
    @(negedge clk);
    if ((sdio_oe || sdout_oe) && sdio_o !== last_bit) hold_err++;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rxb);
    rxb = '0;
    for (int i = 7; i >= 0; i--) begin
      bit_io(tx[i]);
      rxb = {rxb[6:0], last_bit};
    end
  endtask

  task automatic wr(input logic [3:0] a, input int n, input logic [31:0] v);
    logic [7:0] dummy;
    xbyte({1'b0, 2'(n - 1), 1'b0, a}, dummy);
    for (int k = n - 1; k >= 0; k--) xbyte(v[8*k +: 8], dummy);
  endtask

  task automatic rd(input logic [3:0] a, input int n, output logic [31:0] v);
    logic [7:0] b;
    xbyte({1'b1, 2'(n - 1), 1'b0, a}, b);
    v = '0;
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, b);
      v = {v[23:0], b};
    end
  endtask

  task automatic t_reset();
    expect32("R1 cfg reset", cfg_o, 32'h0001_0017);
    expect32("R1 ofs reset", {8'h0, ofs_o}, 32'h0);
    expect32("R1 fsc reset", {8'h0, fsc_o}, 32'h0);
    expect32("R1 enables low", {30'h0, sdio_oe, sdout_oe}, 32'h0);
  endtask

  task automatic t_cal_rw();
    saw_sdio = 1'b0; saw_sdout = 1'b0;
    wr(4'hA, 3, 32'h0012_3456);
    expect32("R10 no drive in write", {30'h0, saw_sdio, saw_sdout}, 32'h0);
    expect32("R4 offset descending write", {8'h0, ofs_o}, 32'h0012_3456);
    rd(4'hA, 3, got);
    expect32("R5 descending read", got, 32'h0012_3456);
    wr(4'hE, 3, 32'h00DE_AD42);
    expect32("R4 full-scale write", {8'h0, fsc_o}, 32'h00DE_AD42);
  endtask

  task automatic t_dor();
    logic [7:0] b;
    rd(4'h2, 3, got);
    expect32("R3 result bytes", got, 32'h00A5_C381);
    saw_sdio = 1'b0; saw_sdout = 1'b0;
    xbyte({1'b1, 2'd0, 1'b0, 4'h0}, b);
    expect32("R10 no drive in instruction", {30'h0, saw_sdio, saw_sdout}, 32'h0);
    xbyte(8'h00, b);
    expect32("R3 result low byte", {24'h0, b}, 32'h81);
    expect32("R9 shared pin used", {30'h0, saw_sdio, saw_sdout}, 32'h2);
  endtask

  task automatic t_byte_order();
    wr(4'h7, 4, 32'h0401_0017);
    expect32("R4 config four-byte write", cfg_o, 32'h0401_0017);
    rd(4'hC, 3, got);
    expect32("R5 ascending read", got, 32'h0042_ADDE);
    rd(4'h0, 3, got);
    expect32("R5 ascending result read", got, 32'h0081_C3A5);
  endtask

  task automatic t_bit_order();
    wr(4'h7, 1, 32'h02);
    expect32("R6 config byte3", cfg_o, 32'h0201_0017);
    rd(4'hA, 1, got);
    expect32("R6 lsb-first read", got, 32'h48);
    wr(4'h8, 1, 32'h9A);
    expect32("R6 write stays msb-first", {8'h0, ofs_o}, 32'h0012_349A);
    rd(4'h8, 1, got);
    expect32("R6 lsb-first read 2", got, 32'h59);
  endtask

  task automatic t_pin_sel();
    wr(4'h7, 1, 32'h01);
    expect32("R9 config byte3", cfg_o, 32'h0101_0017);
    saw_sdio = 1'b0; saw_sdout = 1'b0;
    rd(4'h2, 1, got);
    expect32("R9 dedicated pin data", got, 32'hA5);
    expect32("R9 dedicated pin only", {30'h0, saw_sdio, saw_sdout}, 32'h1);
    wr(4'h7, 1, 32'h00);
    expect32("R9 config restored", cfg_o, 32'h0001_0017);
  endtask

  task automatic t_timeout();
    logic [7:0] b;
    for (int i = 0; i < 4; i++) bit_io(1'b1);
    repeat (200) @(negedge clk);
    rd(4'hA, 1, got);
    expect32("R8 resync after stalled instruction", got, 32'h12);
    xbyte({1'b0, 2'd0, 1'b0, 4'h8}, b);
    for (int i = 0; i < 5; i++) bit_io(1'b1);
    repeat (200) @(negedge clk);
    expect32("R8 partial write discarded", {8'h0, ofs_o}, 32'h0012_349A);
    rd(4'h8, 1, got);
    expect32("R8 resync after stalled write", got, 32'h9A);
    bit_io(1'b1); bit_io(1'b0); bit_io(1'b0); bit_io(1'b0);
    repeat (60) @(negedge clk);
    bit_io(1'b1); bit_io(1'b0); bit_io(1'b0); bit_io(1'b1);
    xbyte(8'h00, b);
    expect32("R8 short stall tolerated", {24'h0, b}, 32'h34);
  endtask

  task automatic t_map_edges();
    wr(4'h1, 1, 32'hFF);
    expect32("R3 result write ignored cfg", cfg_o, 32'h0001_0017);
    expect32("R3 result write ignored ofs", {8'h0, ofs_o}, 32'h0012_349A);
    rd(4'h1, 1, got);
    expect32("R3 result mid byte", got, 32'hC3);
    rd(4'h3, 1, got);
    expect32("R3 hole reads zero", got, 32'h0);
    wr(4'hB, 1, 32'h55);
    expect32("R3 hole write ignored", {8'h0, fsc_o}, 32'h00DE_AD42);
    rd(4'hB, 1, got);
    expect32("R3 hole B reads zero", got, 32'h0);
  endtask

  task automatic t_count();
    rd(4'h7, 2, got);
    expect32("R2 two-byte count", got, 32'h0001);
    rd(4'h4, 1, got);
    expect32("R2 next instruction aligned", got, 32'h17);
    expect32("R7 output held past falling edge", hold_err, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cal_rw();
    t_dor();
    t_byte_order();
    t_bit_order();
    t_pin_sel();
    t_timeout();
    t_map_edges();
    t_count();
    report();
  end
endmodule